// File: doc/BRIEF.md
# Multi-Cycle Shared-Memory Datapath

This block is the 32-bit datapath of a small multi-cycle processor covering word load and store, branch-if-equal, absolute jump and the register-to-register add, subtract, and, or and set-less-than operations. One ALU and one memory port are shared across the clock steps of each instruction. The ALU advances the program counter, forms branch targets and addresses, and computes results. The memory port serves both instruction fetch and data access. Values that must survive from one step to the next sit in five internal registers: instruction, two operand latches, memory data and ALU result.

The block holds no sequencing logic. Every register enable, mux select, memory write and ALU operation is a port, so an external controller, or a bench, drives each step. The opcode and function fields of the held instruction, the ALU zero flag and the signed overflow flag are outputs for that controller. The memory sits outside. It reads without a clock and writes on the clock edge.

Top module: `mc_datapath`

## Requirements
- R1: After reset the program counter equals RESET_PC (default 0), and the instruction, operand and result registers are zero, so `opcode`, `funct` and `mem_wdata` read 0.
- R2: Fetch step (`iord`=0, `ir_we`=1, `alu_src_a`=0, `alu_src_b`=1, `alu_ctl`=010, `pc_we`=1, `pc_src`=0). At one edge the instruction register captures the word at the PC address and the PC becomes PC+4. `opcode` shows bits 31:26 and `funct` shows bits 5:0.
- R3: Decode step (`ab_we`=1, `aluout_we`=1, `alu_src_a`=0, `alu_src_b`=3, add). The operand latches capture the registers named by bits 25:21 and 20:16. The result register captures PC plus the sign-extended bits 15:0 shifted left by 2. `mem_wdata` always shows the second operand latch.
- R4: Register 0 reads as zero, and writes to it are dropped.
- R5: `alu_ctl` selects 000 AND, 001 OR, 010 add, 110 subtract, 111 signed set-less-than (result 1 or 0). `zero` is high exactly when the ALU result is 0.
- R6: `overflow` is the XOR of the carry into and the carry out of bit 31 for add and subtract, and 0 for every other operation.
- R7: Load path. `alu_src_b`=2 adds the sign-extended immediate. `iord`=1 puts the result register on `mem_addr`. `mdr_we` latches `mem_rdata`. `reg_we` with `reg_dst`=0 and `mem_to_reg`=1 writes the memory data register to the register named by bits 20:16.
- R8: Store path. With `iord`=1, `mem_write` asserts `mem_we`, with the result register on `mem_addr` and the second operand on `mem_wdata`.
- R9: `reg_we` with `reg_dst`=1 and `mem_to_reg`=0 writes the result register to the register named by bits 15:11.
- R10: With `pc_cond`=1 and `pc_src`=1, the PC loads the result register when `zero` is high and holds otherwise.
- R11: `pc_we` with `pc_src`=2 loads the PC with PC[31:28], then instruction bits 25:0, then two zero bits.
- R12: With `ir_we` low the instruction register holds. With `pc_we` and `pc_cond` low the PC holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_we | input | 1 | Instruction register load |
| pc_we | input | 1 | Unconditional PC load |
| pc_cond | input | 1 | PC load when zero flag set |
| pc_src | input | 2 | PC source: 0 ALU, 1 result register, 2 jump target |
| iord | input | 1 | Memory address: 0 PC, 1 result register |
| mem_write | input | 1 | Memory write request |
| mdr_we | input | 1 | Memory data register load |
| ab_we | input | 1 | Operand latch load |
| aluout_we | input | 1 | ALU result register load |
| reg_we | input | 1 | Register file write |
| reg_dst | input | 1 | Write index: 0 bits 20:16, 1 bits 15:11 |
| mem_to_reg | input | 1 | Write data: 0 result register, 1 memory data |
| alu_src_a | input | 1 | ALU first input: 0 PC, 1 operand A |
| alu_src_b | input | 2 | ALU second input: 0 operand B, 1 four, 2 immediate, 3 immediate shifted by 2 |
| alu_ctl | input | 3 | ALU operation |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| zero | output | 1 | ALU result is zero |
| overflow | output | 1 | Signed add/subtract overflow |

## Verification
The assertions check on every cycle the rules that tie one step to the next. A fetch adds 4 to the PC, the instruction register captures the fetched word, and the PC and instruction register hold when their enables are low. A branch either loads the latched target or leaves the PC alone. A jump keeps the top PC nibble and word alignment. Register 0 stays zero. Overflow follows the operand and result signs. Only the bench's scenarios can show the data paths that cross many steps: that a loaded value comes back out through a store, that each ALU code gives the right result for chosen operands, and that a decoded branch target lands exactly where the offset points.

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_we,
  input  logic        pc_we,
  input  logic        pc_cond,
  input  logic [1:0]  pc_src,
  input  logic        iord,
  input  logic        mem_write,
  input  logic        mdr_we,
  input  logic        ab_we,
  input  logic        aluout_we,
  input  logic        reg_we,
  input  logic        reg_dst,
  input  logic        mem_to_reg,
  input  logic        alu_src_a,
  input  logic [1:0]  alu_src_b,
  input  logic [2:0]  alu_ctl,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  output logic [5:0]  opcode,
  output logic [5:0]  funct,
  output logic        zero,
  output logic        overflow
);
  localparam int NREG = 32;
  localparam logic [2:0] OP_AND = 3'b000, OP_OR = 3'b001, OP_ADD = 3'b010,
                         OP_SUB = 3'b110, OP_SLT = 3'b111;

  logic [31:0] pc, ir, a_q, b_q, mdr, alu_out;
  logic [31:0] rf [NREG];

  logic [4:0]  rs, rt, wsel;
  logic [31:0] imm, src_a, src_b, b_eff, sum, alu_y, pc_next, wdata;
  logic        sub, c_out, c_msb, ovf_raw;

  assign rs   = ir[25:21];
  assign rt   = ir[20:16];
  assign imm  = {{16{ir[15]}}, ir[15:0]};
  assign wsel = reg_dst ? ir[15:11] : rt;
  assign wdata = mem_to_reg ? mdr : alu_out;

  assign src_a = alu_src_a ? a_q : pc;
  always_comb begin
    case (alu_src_b)
      2'd0: src_b = b_q;
      2'd1: src_b = 32'd4;
      2'd2: src_b = imm;
      default: src_b = {imm[29:0], 2'b00};
    endcase
  end

  assign sub   = alu_ctl[2];
  assign b_eff = sub ? ~src_b : src_b;
  assign {c_out, sum} = {1'b0, src_a} + {1'b0, b_eff} + {32'd0, sub};
  assign c_msb   = src_a[31] ^ b_eff[31] ^ sum[31];
  assign ovf_raw = c_msb ^ c_out;

  always_comb begin
    case (alu_ctl)
      OP_AND:  alu_y = src_a & src_b;
      OP_OR:   alu_y = src_a | src_b;
      OP_ADD,
      OP_SUB:  alu_y = sum;
      OP_SLT:  alu_y = {31'd0, sum[31] ^ ovf_raw};
      default: alu_y = '0;
    endcase
  end

  assign zero     = (alu_y == '0);
  assign overflow = (alu_ctl == OP_ADD || alu_ctl == OP_SUB) ? ovf_raw : 1'b0;

  always_comb begin
    case (pc_src)
      2'd1:    pc_next = alu_out;
      2'd2:    pc_next = {pc[31:28], ir[25:0], 2'b00};
      default: pc_next = alu_y;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc      <= RESET_PC;
      ir      <= '0;
      a_q     <= '0;
      b_q     <= '0;
      mdr     <= '0;
      alu_out <= '0;
    end else begin
      if (pc_we || (pc_cond && zero)) pc <= pc_next;
      if (ir_we)     ir      <= mem_rdata;
      if (mdr_we)    mdr     <= mem_rdata;
      if (aluout_we) alu_out <= alu_y;
      if (ab_we) begin
        a_q <= rf[rs];
        b_q <= rf[rt];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (reg_we && wsel != 5'd0) begin
      rf[wsel] <= wdata;
    end
  end

  assign mem_addr  = iord ? alu_out : pc;
  assign mem_wdata = b_q;
  assign mem_we    = mem_write;
  assign opcode    = ir[31:26];
  assign funct     = ir[5:0];

  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_src == 2'd0 && !alu_src_a && alu_src_b == 2'd1 && alu_ctl == OP_ADD)
      |=> pc == $past(pc) + 32'd4);
  assert_ir_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |=> (opcode == $past(mem_rdata[31:26]) && funct == $past(mem_rdata[5:0])));
  assert_ir_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_we |=> ($stable(opcode) && $stable(funct)));
  assert_pc_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && !pc_cond) |=> $stable(pc));
  assert_branch_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_cond && zero && pc_src == 2'd1) |=> pc == $past(alu_out));
  assert_branch_not_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_cond && !pc_we && !zero) |=> $stable(pc));
  assert_jump_region_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_src == 2'd2) |=> (pc[31:28] == $past(pc[31:28]) && pc[1:0] == 2'b00));
  assert_reg_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf[0] == '0);
  assert_add_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_ctl == OP_ADD && src_a[31] == src_b[31] && alu_y[31] != src_a[31]) |-> overflow);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_ctl != OP_ADD && alu_ctl != OP_SUB) |-> !overflow);
endmodule

// File: tb/mc_datapath_tb_top.sv
module mc_datapath_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_we, pc_we, pc_cond, iord, mem_write, mdr_we, ab_we, aluout_we;
  logic reg_we, reg_dst, mem_to_reg, alu_src_a;
  logic [1:0] pc_src, alu_src_b;
  logic [2:0] alu_ctl;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic mem_we, zero, overflow;
  logic [5:0] opcode, funct;

  logic [31:0] mem [256];
  logic [31:0] exp_pc;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mc_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .ir_we(ir_we), .pc_we(pc_we), .pc_cond(pc_cond),
    .pc_src(pc_src), .iord(iord), .mem_write(mem_write), .mdr_we(mdr_we),
    .ab_we(ab_we), .aluout_we(aluout_we), .reg_we(reg_we), .reg_dst(reg_dst),
    .mem_to_reg(mem_to_reg), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
    .alu_ctl(alu_ctl), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .opcode(opcode), .funct(funct),
    .zero(zero), .overflow(overflow));

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  localparam logic [2:0] C_AND = 3'b000, C_OR = 3'b001, C_ADD = 3'b010,
                         C_SUB = 3'b110, C_SLT = 3'b111;

  function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] im);
    return {op, rs, rt, im};
  endfunction
  function automatic logic [31:0] rtype(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    {ir_we, pc_we, pc_cond, iord, mem_write, mdr_we, ab_we, aluout_we} = '0;
    {reg_we, reg_dst, mem_to_reg, alu_src_a} = '0;
    pc_src = 2'd0; alu_src_b = 2'd0; alu_ctl = 3'd0;
  endtask

  task automatic tick();
    @(posedge clk); #1; clr(); #1;
  endtask

  task automatic fetch(input logic [31:0] w);
    mem[exp_pc[9:2]] = w;
    ir_we = 1; pc_we = 1; alu_src_b = 2'd1; alu_ctl = C_ADD;
    tick();
    exp_pc = exp_pc + 32'd4;
  endtask

  task automatic decode();
    ab_we = 1; aluout_we = 1; alu_src_b = 2'd3; alu_ctl = C_ADD;
    tick();
  endtask

  task automatic exec_addr();
    alu_src_a = 1; alu_src_b = 2'd2; alu_ctl = C_ADD; aluout_we = 1;
    tick();
  endtask

  task automatic set_reg(input logic [4:0] r, input logic [31:0] v);
    logic [31:0] a;
    a = 32'h300 + {25'd0, r, 2'b00};
    mem[a[9:2]] = v;
    fetch(itype(6'h23, 5'd0, r, a[15:0]));
    decode();
    exec_addr();
    iord = 1; mdr_we = 1; tick();
    reg_we = 1; mem_to_reg = 1; tick();
  endtask

  task automatic read_reg(input logic [4:0] r, input logic [31:0] exp, input string tag);
    logic [31:0] a;
    a = 32'h380 + {25'd0, r, 2'b00};
    fetch(itype(6'h2b, 5'd0, r, a[15:0]));
    decode();
    check({tag, " operand B on write data R3"}, mem_wdata, exp);
    exec_addr();
    iord = 1; #1;
    check("R8 store address", mem_addr, a);
    mem_write = 1; #1;
    check("R8 write strobe", {31'd0, mem_we}, 32'd1);
    tick();
    check({tag, " stored value R8"}, mem[a[9:2]], exp);
  endtask

  task automatic run_rtype(input logic [2:0] c, input logic [5:0] fn,
                           input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rt);
    fetch(rtype(rs, rt, rd, fn));
    decode();
    alu_src_a = 1; alu_ctl = c; aluout_we = 1; tick();
    reg_we = 1; reg_dst = 1; tick();
  endtask

  task automatic t_reset();
    check("R1 pc after reset", mem_addr, 32'h0);
    check("R1 opcode after reset", {26'd0, opcode}, 32'd0);
    check("R1 funct after reset", {26'd0, funct}, 32'd0);
    check("R1 operand B after reset", mem_wdata, 32'd0);
  endtask

  task automatic t_fetch();
    fetch(rtype(5'd1, 5'd2, 5'd3, 6'h20));
    check("R2 funct after fetch", {26'd0, funct}, 32'h20);
    check("R2 pc plus four", mem_addr, exp_pc);
    fetch(itype(6'h23, 5'd4, 5'd5, 16'h0010));
    check("R2 opcode after fetch", {26'd0, opcode}, 32'h23);
    check("R2 pc second fetch", mem_addr, 32'd8);
  endtask

  task automatic t_load_store();
    set_reg(5'd1, 32'h1234_5678);
    read_reg(5'd1, 32'h1234_5678, "R7 load r1");
    set_reg(5'd31, 32'hDEAD_BEEF);
    read_reg(5'd31, 32'hDEAD_BEEF, "R7 load r31");
  endtask

  task automatic t_r0();
    set_reg(5'd0, 32'h55);
    read_reg(5'd0, 32'h0, "R4 write to r0 dropped");
  endtask

  task automatic t_decode();
    logic [31:0] p;
    p = exp_pc;
    fetch(itype(6'h04, 5'd1, 5'd31, 16'hFFFD));
    decode();
    iord = 1; #1;
    check("R3 target negative offset", mem_addr, p + 32'd4 - 32'd12);
    check("R3 operand B from rt", mem_wdata, 32'hDEAD_BEEF);
    clr();
    p = exp_pc;
    fetch(itype(6'h04, 5'd0, 5'd0, 16'h0005));
    decode();
    iord = 1; #1;
    check("R3 target positive offset", mem_addr, p + 32'd4 + 32'd20);
    clr();
  endtask

  task automatic t_alu();
    logic [31:0] x, y;
    x = 32'hF0F0_1234; y = 32'h0FF0_0004;
    set_reg(5'd2, x); set_reg(5'd3, y);
    run_rtype(C_ADD, 6'h20, 5'd4, 5'd2, 5'd3); read_reg(5'd4, x + y, "R9 add");
    run_rtype(C_SUB, 6'h22, 5'd4, 5'd2, 5'd3); read_reg(5'd4, x - y, "R5 sub");
    run_rtype(C_AND, 6'h24, 5'd4, 5'd2, 5'd3); read_reg(5'd4, x & y, "R5 and");
    run_rtype(C_OR,  6'h25, 5'd4, 5'd2, 5'd3); read_reg(5'd4, x | y, "R5 or");
    set_reg(5'd5, 32'hFFFF_FFFE); set_reg(5'd6, 32'd3);
    run_rtype(C_SLT, 6'h2A, 5'd7, 5'd5, 5'd6); read_reg(5'd7, 32'd1, "R5 slt neg<pos");
    run_rtype(C_SLT, 6'h2A, 5'd7, 5'd6, 5'd5); read_reg(5'd7, 32'd0, "R5 slt pos<neg");
    set_reg(5'd8, 32'h8000_0000); set_reg(5'd9, 32'h7FFF_FFFF);
    run_rtype(C_SLT, 6'h2A, 5'd7, 5'd8, 5'd9); read_reg(5'd7, 32'd1, "R5 slt min<max");
  endtask

  task automatic ovf_case(input logic [4:0] rs, input logic [4:0] rt,
                          input logic [2:0] c, input logic exp, input string tag);
    fetch(rtype(rs, rt, 5'd0, 6'h20));
    decode();
    alu_src_a = 1; alu_ctl = c; #1;
    check(tag, {31'd0, overflow}, {31'd0, exp});
    clr(); #1;
  endtask

  task automatic t_ovf();
    set_reg(5'd10, 32'h7FFF_FFFF); set_reg(5'd11, 32'd1); set_reg(5'd12, 32'h8000_0000);
    ovf_case(5'd10, 5'd11, C_ADD, 1'b1, "R6 add max+1");
    ovf_case(5'd12, 5'd11, C_SUB, 1'b1, "R6 sub min-1");
    ovf_case(5'd11, 5'd11, C_ADD, 1'b0, "R6 add 1+1");
    ovf_case(5'd10, 5'd11, C_SUB, 1'b0, "R6 sub max-1");
    ovf_case(5'd10, 5'd11, C_OR,  1'b0, "R6 or never overflows");
  endtask

  task automatic t_beq();
    logic [31:0] p;
    set_reg(5'd13, 32'd77); set_reg(5'd14, 32'd77); set_reg(5'd15, 32'd5);
    p = exp_pc;
    fetch(itype(6'h04, 5'd13, 5'd14, 16'h0004));
    decode();
    alu_src_a = 1; alu_ctl = C_SUB; pc_cond = 1; pc_src = 2'd1; #1;
    check("R5 zero on equal", {31'd0, zero}, 32'd1);
    tick();
    exp_pc = p + 32'd4 + 32'd16;
    check("R10 branch taken", mem_addr, exp_pc);
    fetch(itype(6'h04, 5'd13, 5'd15, 16'h0004));
    decode();
    alu_src_a = 1; alu_ctl = C_SUB; pc_cond = 1; pc_src = 2'd1; #1;
    check("R5 zero low on unequal", {31'd0, zero}, 32'd0);
    tick();
    check("R10 branch not taken", mem_addr, exp_pc);
  endtask

  task automatic t_jump();
    fetch({6'h02, 26'h60});
    pc_we = 1; pc_src = 2'd2; tick();
    exp_pc = {exp_pc[31:28], 26'h60, 2'b00};
    check("R11 jump target", mem_addr, exp_pc);
  endtask

  task automatic t_hold();
    logic [5:0] op0, fn0;
    fetch(rtype(5'd1, 5'd1, 5'd1, 6'h25));
    op0 = opcode; fn0 = funct;
    mem[exp_pc[9:2]] = {6'h02, 26'h3};
    alu_src_b = 2'd1; alu_ctl = C_ADD; tick();
    alu_src_b = 2'd1; alu_ctl = C_ADD; tick();
    check("R12 pc holds", mem_addr, exp_pc);
    check("R12 instruction holds", {20'd0, opcode, funct}, {20'd0, op0, fn0});
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    clr();
    exp_pc = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    t_reset();
    t_fetch();
    t_load_store();
    t_r0();
    t_decode();
    t_alu();
    t_ovf();
    t_beq();
    t_jump();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule